// File: doc/BRIEF.md
# System Clock Source Controller

This block decides which of three sources drives the system clock: an always-available internal oscillator, an external oscillator, or a PLL. Software controls it through a small word-addressed register port. Writing the control word enables or disables the external oscillator and the PLL. A separate word holds the PLL divider and multiplier settings. A third word carries a source request together with a read-only field that reports the source in use.

Real oscillators and PLL lock are not modelled. Each of the two switchable sources has a settling counter with a parameter for its length. A source reports ready once its enable has been held for that many cycles. The active source follows the request only when the requested source is ready. The enable of the source in use cannot be cleared, so software cannot remove the clock it is running on. The PLL output divider is stored as half its value minus one. A decoded copy is offered at the ports together with the other PLL settings.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, word 0 (control) reads 0x00000001, word 1 (PLL settings) reads 0x24003010, word 2 (source select) reads 0x00000000, word 3 reads 0, and `sysClkSel` is 0.
- R2: The external-oscillator ready flag is control bit 17. It reads 1 from the EXT_SETTLE-th clock edge after the edge that writes 1 to enable bit 16, and reads 0 before that edge.
- R3: The PLL ready flag is control bit 25. It reads 1 from the PLL_SETTLE-th clock edge after the edge that writes 1 to PLL enable bit 24, and reads 0 before that edge.
- R4: A ready flag reads 0 directly after the edge on which its enable is cleared.
- R5: The request field is word 2 bits 1:0 and the status field is word 2 bits 3:2. Both use 0 = internal, 1 = external, 2 = PLL. When the requested source is ready, the status field and `sysClkSel` take the request one edge after the write edge.
- R6: A request for a source that is not ready leaves the status unchanged. The status takes the request on the edge after the source's ready flag rises.
- R7: Writes to bits 17 and 25 of word 0 and to bits 3:2 of word 2 have no effect.
- R8: A write that clears the enable of the active source (bit 0 internal, bit 16 external, bit 24 PLL) leaves that enable set. After the status has moved away from that source, the same write clears it.
- R9: The writable PLL-settings bits are 5:0 (M), 14:6 (N), 17:16 (P code), 22 (external input) and 27:24 (Q). All other bits keep their reset value: bit 29 reads 1 and the rest read 0. `pllDivM`, `pllMulN`, `pllDivQ` and `pllSrcExt` present those fields.
- R10: `pllDivP` presents the P code decoded as 2*(code+1), which gives 2, 4, 6 or 8.
- R11: A request value of 3 never changes the status. It reads back in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Word select: 0 control, 1 PLL settings, 2 source select |
| wrEn | input | 1 | Write strobe for the addressed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed word (combinational) |
| sysClkSel | output | 2 | Source in use: 0 internal, 1 external, 2 PLL |
| pllDivM | output | 6 | PLL input divider field |
| pllMulN | output | 9 | PLL multiplier field |
| pllDivP | output | 4 | Decoded PLL output divider |
| pllDivQ | output | 4 | PLL Q divider field |
| pllSrcExt | output | 1 | PLL takes the external oscillator as input |

## Verification
The bench builds the block with EXT_SETTLE = 5 and PLL_SETTLE = 9. These short and distinct settling times let the bench sample each ready flag on the cycle before and the cycle after it rises. They also put the not-ready window of a pending PLL request, the switch edge that follows it, and the protection of the source in use inside a few dozen cycles, with each event on a cycle of its own.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int DATA_W = 32;

  // source codes shared by request and status fields
  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_PLL = 2'd2;

  // word addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PLL  = 2'd1;
  localparam logic [1:0] ADDR_SEL  = 2'd2;

  // control word bit positions
  localparam int CTL_INT_EN  = 0;
  localparam int CTL_EXT_EN  = 16;
  localparam int CTL_EXT_RDY = 17;
  localparam int CTL_BYPASS  = 18;
  localparam int CTL_GUARD   = 19;
  localparam int CTL_PLL_EN  = 24;
  localparam int CTL_PLL_RDY = 25;

  localparam logic [DATA_W-1:0] PLL_RESET = 32'h2400_3010;
  localparam logic [DATA_W-1:0] PLL_WMASK = 32'h0F43_7FFF;

  // strobes from control to datapath
  typedef struct packed {
    logic       statusLoad;
    logic [1:0] newStatus;
    logic [1:0] keepSrc;
    logic       extRdy;
    logic       pllRdy;
  } clkStrobe_t;
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  clkStrobe_t        strb,
  output logic              intEn,
  output logic              extEn,
  output logic              pllEn,
  output logic [1:0]        reqSrc,
  output logic [1:0]        actSrc,
  output logic [DATA_W-1:0] rdData,
  output logic [5:0]        pllDivM,
  output logic [8:0]        pllMulN,
  output logic [3:0]        pllDivP,
  output logic [3:0]        pllDivQ,
  output logic              pllSrcExt
);
  logic bypassEn, guardEn;
  logic [DATA_W-1:0] pllCfg;
  logic ctrlWr, pllWr, selWr;

  assign ctrlWr = wrEn && (regAddr == ADDR_CTRL);
  assign pllWr  = wrEn && (regAddr == ADDR_PLL);
  assign selWr  = wrEn && (regAddr == ADDR_SEL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn    <= 1'b1;
      extEn    <= 1'b0;
      pllEn    <= 1'b0;
      bypassEn <= 1'b0;
      guardEn  <= 1'b0;
      pllCfg   <= PLL_RESET;
      reqSrc   <= SRC_INT;
      actSrc   <= SRC_INT;
    end else begin
      if (ctrlWr) begin
        // the source in use (or being switched to) keeps its enable
        intEn    <= wrData[CTL_INT_EN] | (strb.keepSrc == SRC_INT);
        extEn    <= wrData[CTL_EXT_EN] | (strb.keepSrc == SRC_EXT);
        pllEn    <= wrData[CTL_PLL_EN] | (strb.keepSrc == SRC_PLL);
        bypassEn <= wrData[CTL_BYPASS];
        guardEn  <= wrData[CTL_GUARD];
      end
      if (pllWr) pllCfg <= (wrData & PLL_WMASK) | (pllCfg & ~PLL_WMASK);
      if (selWr) reqSrc <= wrData[1:0];
      if (strb.statusLoad) actSrc <= strb.newStatus;
    end
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        rdData[CTL_INT_EN]  = intEn;
        rdData[CTL_EXT_EN]  = extEn;
        rdData[CTL_EXT_RDY] = strb.extRdy;
        rdData[CTL_BYPASS]  = bypassEn;
        rdData[CTL_GUARD]   = guardEn;
        rdData[CTL_PLL_EN]  = pllEn;
        rdData[CTL_PLL_RDY] = strb.pllRdy;
      end
      ADDR_PLL: rdData = pllCfg;
      ADDR_SEL: rdData[3:0] = {actSrc, reqSrc};
      default:  rdData = '0;
    endcase
  end

  assign pllDivM   = pllCfg[5:0];
  assign pllMulN   = pllCfg[14:6];
  assign pllDivP   = {1'b0, pllCfg[17:16], 1'b0} + 4'd2;
  assign pllDivQ   = pllCfg[27:24];
  assign pllSrcExt = pllCfg[22];
endmodule

// File: rtl/sysclk_ctrl_fsm.sv
module sysclk_ctrl_fsm
  import sysclk_pkg::*;
#(
  parameter int EXT_SETTLE = 16,
  parameter int PLL_SETTLE = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       intEn,
  input  logic       extEn,
  input  logic       pllEn,
  input  logic [1:0] reqSrc,
  input  logic [1:0] actSrc,
  output clkStrobe_t strb
);
  localparam int MAX_SETTLE = (EXT_SETTLE > PLL_SETTLE) ? EXT_SETTLE : PLL_SETTLE;
  localparam int CNT_W = $clog2(MAX_SETTLE + 1) < 1 ? 1 : $clog2(MAX_SETTLE + 1);

  logic [1:0] oscEn, oscRdy;
  logic reqReady;

  assign oscEn = {pllEn, extEn};

  // one settling counter per switchable source: index 0 external, 1 PLL
  for (genvar g = 0; g < 2; g++) begin : g_settle
    localparam int LIMIT = (g == 0) ? EXT_SETTLE : PLL_SETTLE;
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN || !oscEn[g]) cnt <= '0;
      else if (cnt != CNT_W'(LIMIT)) cnt <= cnt + 1'b1;
    end
    assign oscRdy[g] = oscEn[g] && (cnt == CNT_W'(LIMIT));
  end

  always_comb begin
    case (reqSrc)
      SRC_INT: reqReady = intEn;
      SRC_EXT: reqReady = oscRdy[0];
      SRC_PLL: reqReady = oscRdy[1];
      default: reqReady = 1'b0;
    endcase
  end

  assign strb.statusLoad = (reqSrc != actSrc) && reqReady;
  assign strb.newStatus  = reqSrc;
  assign strb.keepSrc    = strb.statusLoad ? reqSrc : actSrc;
  assign strb.extRdy     = oscRdy[0];
  assign strb.pllRdy     = oscRdy[1];
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int EXT_SETTLE = 16,
  parameter int PLL_SETTLE = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [1:0]  sysClkSel,
  output logic [5:0]  pllDivM,
  output logic [8:0]  pllMulN,
  output logic [3:0]  pllDivP,
  output logic [3:0]  pllDivQ,
  output logic        pllSrcExt
);
  clkStrobe_t strb;
  logic intEn, extEn, pllEn;
  logic [1:0] reqSrc, actSrc;
  logic extRdy, pllRdy;

  sysclk_ctrl_fsm #(.EXT_SETTLE(EXT_SETTLE), .PLL_SETTLE(PLL_SETTLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .intEn(intEn), .extEn(extEn), .pllEn(pllEn),
    .reqSrc(reqSrc), .actSrc(actSrc), .strb(strb)
  );

  sysclk_regs regs_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .strb(strb), .intEn(intEn), .extEn(extEn), .pllEn(pllEn),
    .reqSrc(reqSrc), .actSrc(actSrc), .rdData(rdData),
    .pllDivM(pllDivM), .pllMulN(pllMulN), .pllDivP(pllDivP),
    .pllDivQ(pllDivQ), .pllSrcExt(pllSrcExt)
  );

  assign extRdy    = strb.extRdy;
  assign pllRdy    = strb.pllRdy;
  assign sysClkSel = actSrc;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int EXT_SETTLE = 16,
  parameter int PLL_SETTLE = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] sysClkSel,
  input logic       intEn,
  input logic       extEn,
  input logic       pllEn,
  input logic       extRdy,
  input logic       pllRdy,
  input logic [3:0] pllDivP
);
  localparam int MAXS = (EXT_SETTLE > PLL_SETTLE) ? EXT_SETTLE : PLL_SETTLE;
  localparam int AW = $clog2(MAXS + 2);

  logic [AW-1:0] extAge, pllAge;
  logic [3:0] rdyPrev;
  logic activeOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extAge  <= '0;
      pllAge  <= '0;
      rdyPrev <= 4'b0001;
    end else begin
      extAge  <= !extEn ? '0 : (extAge == AW'(MAXS + 1) ? extAge : extAge + 1'b1);
      pllAge  <= !pllEn ? '0 : (pllAge == AW'(MAXS + 1) ? pllAge : pllAge + 1'b1);
      rdyPrev <= {1'b0, pllRdy, extRdy, intEn};
    end
  end

  always_comb begin
    case (sysClkSel)
      2'd0:    activeOn = intEn;
      2'd1:    activeOn = extEn;
      2'd2:    activeOn = pllEn;
      default: activeOn = 1'b0;
    endcase
  end

  AST_EXT_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extRdy) |-> (extAge == AW'(EXT_SETTLE))); // R2
  AST_PLL_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllRdy) |-> (pllAge == AW'(PLL_SETTLE))); // R3
  AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (extRdy |-> extEn) and (pllRdy |-> pllEn)); // R4
  AST_SWITCH_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sysClkSel) |-> rdyPrev[sysClkSel]); // R6
  AST_ACTIVE_KEPT_ON: assert property (@(posedge clk) disable iff (!rstN)
    activeOn); // R8
  AST_STATUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    sysClkSel != 2'd3); // R11
  AST_DIVP_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    !pllDivP[0] && pllDivP >= 4'd2 && pllDivP <= 4'd8); // R10
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.EXT_SETTLE(EXT_SETTLE), .PLL_SETTLE(PLL_SETTLE)) chk_i (
  .clk(clk), .rstN(rstN), .sysClkSel(sysClkSel), .intEn(intEn), .extEn(extEn),
  .pllEn(pllEn), .extRdy(extRdy), .pllRdy(pllRdy), .pllDivP(pllDivP)
);

// File: tb/sysclk_ctrl_tb_top.sv
module sysclk_ctrl_tb_top;
  localparam int EXT_S = 5;
  localparam int PLL_S = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0] sysClkSel;
  logic [5:0] pllDivM;
  logic [8:0] pllMulN;
  logic [3:0] pllDivP, pllDivQ;
  logic pllSrcExt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysclk_ctrl #(.EXT_SETTLE(EXT_S), .PLL_SETTLE(PLL_S)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .sysClkSel(sysClkSel), .pllDivM(pllDivM), .pllMulN(pllMulN),
    .pllDivP(pllDivP), .pllDivQ(pllDivQ), .pllSrcExt(pllSrcExt)
  );

  // {write data, expected readback, expected decoded P}
  localparam logic [67:0] PLL_VEC [5] = '{
    {32'hFFFF_FFFF, 32'h2F43_7FFF, 4'd8},
    {32'h0000_0000, 32'h2000_0000, 4'd2},
    {32'h0740_5408, 32'h2740_5408, 4'd2},
    {32'h8841_5A08, 32'h2841_5A08, 4'd4},
    {32'h0002_0000, 32'h2002_0000, 4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h0000_0001);
    rd(2'd1, d); check("R1 pll", d, 32'h2400_3010);
    rd(2'd2, d); check("R1 sel", d, 32'h0);
    rd(2'd3, d); check("R1 word3", d, 32'h0);
    check("R1 sysClkSel", 32'(sysClkSel), 32'h0);
    check("R10 reset P", 32'(pllDivP), 32'd2);

    // R9 R10 PLL settings table
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w, e;
      logic [3:0] p;
      {w, e, p} = PLL_VEC[i];
      wr(2'd1, w);
      rd(2'd1, d);
      check("R9 pll readback", d, e);
      check("R10 decoded P", 32'(pllDivP), 32'(p));
      check("R9 M field", 32'(pllDivM), 32'(e[5:0]));
      check("R9 N field", 32'(pllMulN), 32'(e[14:6]));
      check("R9 Q field", 32'(pllDivQ), 32'(e[27:24]));
      check("R9 src field", 32'(pllSrcExt), 32'(e[22]));
    end

    // R7 ready bits and status field not writable
    wr(2'd0, 32'h0202_0001);
    rd(2'd0, d); check("R7 ready bits write", d, 32'h0000_0001);
    wr(2'd2, 32'h0000_000C);
    rd(2'd2, d); check("R7 status write", d, 32'h0);
    cyc(1);
    rd(2'd2, d); check("R7 status write later", d, 32'h0);

    // R2 external ready timing
    wr(2'd0, 32'h0001_0001);
    cyc(EXT_S - 1);
    rd(2'd0, d); check("R2 ext not yet ready", d, 32'h0001_0001);
    cyc(1);
    rd(2'd0, d); check("R2 ext ready", d, 32'h0003_0001);

    // R5 switch to external
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, d); check("R5 status before edge", d, 32'h0000_0001);
    cyc(1);
    rd(2'd2, d); check("R5 status ext", d, 32'h0000_0005);
    check("R5 sysClkSel ext", 32'(sysClkSel), 32'h1);

    // R8 active external cannot be disabled
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, d); check("R8 ext kept on", d, 32'h0003_0001);

    // R3 R6 PLL requested before it is ready
    wr(2'd0, 32'h0101_0001);
    wr(2'd2, 32'h0000_0002);
    cyc(PLL_S - 2);
    rd(2'd0, d); check("R3 pll not yet ready", d, 32'h0103_0001);
    check("R6 status held", 32'(sysClkSel), 32'h1);
    cyc(1);
    rd(2'd0, d); check("R3 pll ready", d, 32'h0303_0001);
    check("R6 status held at ready", 32'(sysClkSel), 32'h1);
    cyc(1);
    rd(2'd2, d); check("R6 status pll", d, 32'h0000_000A);

    // R8 R4 external clearable once no longer active
    wr(2'd0, 32'h0100_0001);
    rd(2'd0, d); check("R4 R8 ext cleared", d, 32'h0300_0001);

    // R11 invalid request
    wr(2'd2, 32'h0000_0003);
    cyc(2);
    rd(2'd2, d); check("R11 request 3 ignored", d, 32'h0000_000B);

    // back to internal, then PLL clears
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, d); check("R5 before edge int", d, 32'h0000_0008);
    cyc(1);
    rd(2'd2, d); check("R5 status int", d, 32'h0);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, d); check("R4 pll ready cleared", d, 32'h0000_0001);

    // R8 internal active cannot be disabled
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); check("R8 int kept on", d, 32'h0000_0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule